// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block serialises one data word at a time onto an asynchronous serial line. The shape of each character comes from a set of static configuration inputs: how many data bits are sent, whether a parity bit is added and of which sense, and whether one or two stop bits close the character. Words enter through a valid/ready handshake. Each bit is held on the line for sixteen pulses of a baud tick that is generated outside the block.

Sending can be held back by a clear-to-send input. In loopback mode, the block's own request-to-send level replaces the clear-to-send input, and the serial output is also routed to the receive-side input, while it still drives the external line. A global enable input holds every internal register in its idle state while it is low. When enable goes high again, the transmitter is ready at once.

Top module: `uart_frame_tx`

## Requirements
- R1: The line idles high. A character is a low start bit followed by the data bits, least significant first. Every bit, including the start bit, lasts exactly 16 baud ticks, counted from the cycle in which the word is accepted.
- R2: The data length code `cfg_len` gives the number of data bits: 0 gives 7, 1 gives 8, 2 gives 9. Code 3 is reserved and behaves as 8. Bits of `in_data` above the selected length are not sent.
- R3: The parity code `cfg_parity` works as follows. Code 0 sends no parity bit. Code 2 sends a bit that makes the count of ones over the data bits and the parity bit even. Code 3 makes that count odd. Reserved code 1 behaves as code 0. The parity bit follows the last data bit.
- R4: `cfg_two_stop`=0 ends the character with one high stop bit, and 1 ends it with two. After the last stop bit the block is idle.
- R5: `in_ready` is high only while the block is enabled, idle and allowed to send. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The start bit appears on `tx_out` from the next cycle, and `in_ready` is low for the whole character.
- R6: With `cfg_cts_en`=1 and `cfg_loopback`=0, the block starts a character only while `cts_in` is high. Dropping `cts_in` during a character does not cut it short. With `cfg_cts_en`=0, `cts_in` has no effect.
- R7: With `cfg_loopback`=1, `rx_core` equals `tx_out`, and flow control (when enabled) uses `rx_rts_req` in place of `cts_in`. With `cfg_loopback`=0, `rx_core` equals `rx_pin`. `rts_out` always equals `rx_rts_req`.
- R8: While `en` is low, `tx_out` is high from the next cycle on, `in_ready` is low, and any character in progress is dropped. In the cycle `en` returns high, `in_ready` is high if flow control allows.
- R9: In a cycle without a baud tick and without an accepted word, `tx_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global enable; low holds all state idle |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_len | input | 2 | Data length code |
| cfg_parity | input | 2 | Parity code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_cts_en | input | 1 | 1 enables clear-to-send gating |
| cfg_loopback | input | 1 | 1 selects internal loopback |
| in_valid | input | 1 | Data word offered |
| in_data | input | 9 | Data word, least significant bit sent first |
| in_ready | output | 1 | Block accepts a word this cycle |
| tx_out | output | 1 | Serial line output |
| cts_in | input | 1 | Clear-to-send from the far end, high allows sending |
| rx_rts_req | input | 1 | Request-to-send level from the local receiver |
| rts_out | output | 1 | Request-to-send pin |
| rx_pin | input | 1 | External serial receive line |
| rx_core | output | 1 | Serial input presented to the receiver |

## Verification
Two events can coincide. One is a clear-to-send drop in the very cycle that ends a character's last stop bit, when the block would otherwise accept the next word. The other is an enable drop in a cycle where a baud tick moves a bit forward. The bench drops `cts_in` right after a word is accepted and confirms that the character still completes unchanged and that `in_ready` stays low at the end of the frame. It also removes `en` in the middle of a start bit and expects an idle line one cycle later, with readiness returning in the same cycle that enable comes back. Random frames with baud tick spacings of 1 to 3 cycles move the tick phase relative to the handshake edge. Each frame is compared bit by bit with a frame the bench builds itself.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 9;
    localparam int FRAME_W = 1 + DATA_W + 1 + 2;
    localparam int NBITS_W = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        LEN_7   = 2'd0,
        LEN_8   = 2'd1,
        LEN_9   = 2'd2,
        LEN_RSV = 2'd3
    } len_code_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_RSV  = 2'd1,
        PAR_EVEN = 2'd2,
        PAR_ODD  = 2'd3
    } par_code_e;

    typedef struct packed {
        len_code_e len;
        par_code_e parity;
        logic      two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;   // bit 0 leaves first
        logic [NBITS_W-1:0] nbits;
    } frame_t;

    function automatic int data_count(len_code_e l);
        case (l)
            LEN_7:   return 7;
            LEN_9:   return 9;
            default: return 8;       // 8 and reserved
        endcase
    endfunction

    // Assemble start, data, optional parity and stop bits; unused tail stays high.
    function automatic frame_t build_frame(frame_cfg_t c, logic [DATA_W-1:0] d);
        frame_t f;
        int     n;
        int     pos;
        logic   odd_ones;
        n        = data_count(c.len);
        f.bits   = '1;
        f.bits[0] = 1'b0;
        odd_ones = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                f.bits[1 + i] = d[i];
                odd_ones      = odd_ones ^ d[i];
            end
        end
        pos = 1 + n;
        if (c.parity == PAR_EVEN || c.parity == PAR_ODD) begin
            f.bits[pos] = (c.parity == PAR_ODD) ? ~odd_ones : odd_ones;
            pos = pos + 1;
        end
        pos     = pos + (c.two_stop ? 2 : 1);
        f.nbits = NBITS_W'(pos);
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic bit_done
);
    localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_done = run && tick && (cnt == LAST);
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  logic   load,
    input  frame_t frame,
    input  logic   advance,
    output logic   tx,
    output logic   busy
);
    logic [FRAME_W-1:0] sr;
    logic [NBITS_W-1:0] left;

    always_ff @(posedge clk) begin
        if (clr) begin
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            sr   <= frame.bits;
            left <= frame.nbits;
        end else if (advance && left != '0) begin
            sr   <= {1'b1, sr[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end

    assign tx   = sr[0];
    assign busy = (left != '0);
endmodule

// File: rtl/uart_tx_route.sv
module uart_tx_route (
    input  logic loopback,
    input  logic cts_en,
    input  logic cts_in,
    input  logic rts_req,
    input  logic rx_pin,
    input  logic tx,
    output logic may_send,
    output logic rts_out,
    output logic rx_core
);
    logic cts_seen;

    assign rts_out  = rts_req;
    assign cts_seen = loopback ? rts_req : cts_in;
    assign may_send = !cts_en || cts_seen;
    assign rx_core  = loopback ? tx : rx_pin;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              baud_tick,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_parity,
    input  logic              cfg_two_stop,
    input  logic              cfg_cts_en,
    input  logic              cfg_loopback,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_out,
    input  logic              cts_in,
    input  logic              rx_rts_req,
    output logic              rts_out,
    input  logic              rx_pin,
    output logic              rx_core
);
    logic       clr;
    logic       busy;
    logic       bit_done;
    logic       may_send;
    logic       accept;
    frame_cfg_t cfg;
    frame_t     frame;

    assign clr      = rst || !en;
    assign cfg      = '{len: len_code_e'(cfg_len), parity: par_code_e'(cfg_parity),
                        two_stop: cfg_two_stop};
    assign frame    = build_frame(cfg, in_data);
    assign in_ready = en && !busy && may_send;
    assign accept   = in_valid && in_ready;

    uart_tx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) i_bitclk (
        .clk      (clk),
        .clr      (clr),
        .run      (busy),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    uart_tx_shifter i_shifter (
        .clk     (clk),
        .clr     (clr),
        .load    (accept),
        .frame   (frame),
        .advance (bit_done),
        .tx      (tx_out),
        .busy    (busy)
    );

    uart_tx_route i_route (
        .loopback (cfg_loopback),
        .cts_en   (cfg_cts_en),
        .cts_in   (cts_in),
        .rts_req  (rx_rts_req),
        .rx_pin   (rx_pin),
        .tx       (tx_out),
        .may_send (may_send),
        .rts_out  (rts_out),
        .rx_core  (rx_core)
    );
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic baud_tick,
    input logic in_valid,
    input logic in_ready,
    input logic tx_out,
    input logic cts_in,
    input logic rx_rts_req,
    input logic cfg_cts_en,
    input logic cfg_loopback,
    input logic rx_pin,
    input logic rx_core
);
    // R1: an idle, ready transmitter holds the line high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_out);

    // R5: an accepted word starts with a low bit and blocks further words
    a_r5_start_bit: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!tx_out && !in_ready));

    // R6: external clear-to-send low blocks new words
    a_r6_cts_block: assert property (@(posedge clk) disable iff (rst)
        (cfg_cts_en && !cfg_loopback && !cts_in) |-> !in_ready);

    // R7: in loopback, own request level gates sending and output feeds receiver
    a_r7_loop_cts: assert property (@(posedge clk) disable iff (rst)
        (cfg_cts_en && cfg_loopback && !rx_rts_req) |-> !in_ready);

    a_r7_rx_route: assert property (@(posedge clk) disable iff (rst)
        rx_core == (cfg_loopback ? tx_out : rx_pin));

    // R8: disabled block is idle
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> tx_out);

    a_r8_disable_ready: assert property (@(posedge clk) disable iff (rst)
        !en |-> !in_ready);

    // R9: no tick and no new word means a steady line
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !baud_tick && !(in_valid && in_ready)) |=> $stable(tx_out));
endmodule

bind uart_frame_tx uart_tx_checker i_checker (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .baud_tick    (baud_tick),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .tx_out       (tx_out),
    .cts_in       (cts_in),
    .rx_rts_req   (rx_rts_req),
    .cfg_cts_en   (cfg_cts_en),
    .cfg_loopback (cfg_loopback),
    .rx_pin       (rx_pin),
    .rx_core      (rx_core)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int OS = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic [1:0] cfg_parity = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_cts_en = 1'b0;
    logic       cfg_loopback = 1'b0;
    logic       in_valid = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_ready;
    logic       tx_out;
    logic       cts_in = 1'b1;
    logic       rx_rts_req = 1'b1;
    logic       rts_out;
    logic       rx_pin = 1'b1;
    logic       rx_core;

    int n_checks = 0;
    int n_err = 0;
    int tick_per = 1;
    int phase = 0;
    bit tick_hold = 1'b0;
    int seen = 0;

    uart_frame_tx #(.OVERSAMPLE(OS)) i_uart_frame_tx (
        .clk(clk), .rst(rst), .en(en), .baud_tick(baud_tick),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .cfg_cts_en(cfg_cts_en), .cfg_loopback(cfg_loopback),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .tx_out(tx_out), .cts_in(cts_in), .rx_rts_req(rx_rts_req),
        .rts_out(rts_out), .rx_pin(rx_pin), .rx_core(rx_core)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Baud tick source and tick counter, both updated away from the active edge
    always @(negedge clk) begin
        if (baud_tick) seen = seen + 1;
        if (tick_hold) begin
            baud_tick = 1'b0;
        end else begin
            phase = phase + 1;
            if (phase >= tick_per) phase = 0;
            baud_tick = (phase == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic void exp_frame(input logic [8:0] d, output logic [12:0] f,
                                      output int n);
        int nd;
        int ones;
        nd   = (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd2) ? 9 : 8;
        ones = 0;
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[1 + i] = d[i];
            ones += int'(d[i]);
        end
        n = 1 + nd;
        if (cfg_parity == 2'd2) begin
            f[n] = (ones % 2 == 1);
            n++;
        end else if (cfg_parity == 2'd3) begin
            f[n] = (ones % 2 == 0);
            n++;
        end
        n += cfg_two_stop ? 2 : 1;
    endfunction

    // Offer a word, wait for acceptance, then zero the bench tick count
    task automatic accept_word(input logic [8:0] d);
        int guard;
        in_data  = d;
        in_valid = 1'b1;
        guard    = 0;
        while (!in_ready && guard < 5000) begin
            step();
            guard++;
        end
        @(posedge clk);
        step();
        in_valid = 1'b0;
        seen     = 0;
    endtask

    task automatic send(input logic [8:0] d, input bit drop_cts, input string tag);
        logic [12:0] exp;
        logic [12:0] got;
        int          n;
        bit          loop_ok;
        exp_frame(d, exp, n);
        accept_word(d);
        chk(!tx_out && !in_ready, {"R5 start after accept ", tag}, {tx_out, in_ready}, 2'b00);
        if (drop_cts) cts_in = 1'b0;
        got     = '1;
        loop_ok = 1'b1;
        for (int b = 0; b < n; b++) begin
            while (seen < OS * b + OS / 2) step();
            got[b] = tx_out;
            if (cfg_loopback) loop_ok &= (rx_core === tx_out);
            if (b > 0) loop_ok &= (in_ready == 1'b0);
        end
        chk(got == exp, {"R1 R2 R3 R4 frame ", tag}, got, exp);
        if (cfg_loopback) chk(loop_ok, {"R7 loopback rx ", tag}, rx_core, tx_out);
        while (seen < OS * n) step();
        if (drop_cts)
            chk(tx_out && !in_ready, {"R6 cts drop completes ", tag}, {tx_out, in_ready}, 2'b10);
        else
            chk(tx_out && in_ready, {"R4 idle after stop ", tag}, {tx_out, in_ready}, 2'b11);
        cts_in = 1'b1;
    endtask

    initial begin
        bit ok;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(posedge clk);
        step();
        rst = 1'b0;
        step();
        chk(tx_out && in_ready, "R1 reset state", {tx_out, in_ready}, 2'b11);

        // R2 length codes, R3 parity codes, R4 stop lengths
        cfg_len = 2'd0; cfg_parity = 2'd0; send(9'h1A5, 0, "len7 upper ignored");
        cfg_len = 2'd1; cfg_parity = 2'd2; send(9'h0B3, 0, "len8 even");
        cfg_len = 2'd2; cfg_parity = 2'd3; send(9'h1C4, 0, "len9 odd");
        cfg_len = 2'd3; cfg_parity = 2'd1; cfg_two_stop = 1'b1; send(9'h1FF, 0, "reserved codes");
        cfg_len = 2'd1; cfg_parity = 2'd3; send(9'h000, 0, "odd zeros two stop");
        cfg_two_stop = 1'b0;

        // R6 flow control gating
        cfg_cts_en = 1'b1; cts_in = 1'b0; in_valid = 1'b1; in_data = 9'h055;
        ok = 1'b1;
        repeat (30) begin step(); ok &= (!in_ready && tx_out); end
        chk(ok, "R6 cts low blocks start", {in_ready, tx_out}, 2'b01);
        in_valid = 1'b0; cts_in = 1'b1;
        send(9'h055, 0, "cts high");
        send(9'h0E1, 1, "cts drop mid frame");
        cfg_cts_en = 1'b0; cts_in = 1'b0; step();
        chk(in_ready, "R6 cts ignored when off", in_ready, 1'b1);
        cts_in = 1'b1;

        // R7 loopback routing
        rx_pin = 1'b0; step();
        chk(rx_core == rx_pin, "R7 normal rx from pin", rx_core, rx_pin);
        rx_pin = 1'b1;
        cfg_loopback = 1'b1; cfg_cts_en = 1'b1; cts_in = 1'b1; rx_rts_req = 1'b0; step();
        chk(!in_ready && rts_out == 1'b0, "R7 loop uses own rts", {in_ready, rts_out}, 2'b00);
        cts_in = 1'b0; rx_rts_req = 1'b1; step();
        chk(in_ready && rts_out, "R7 loop ignores cts pin", {in_ready, rts_out}, 2'b11);
        cfg_parity = 2'd2;
        send(9'h13C, 0, "loopback");
        cfg_loopback = 1'b0; cfg_cts_en = 1'b0; cts_in = 1'b1;

        // R8 enable drop mid frame
        accept_word(9'h0F0);
        repeat (5) step();
        chk(!tx_out, "R8 start bit before disable", tx_out, 1'b0);
        en = 1'b0;
        step();
        chk(tx_out && !in_ready, "R8 disabled idle", {tx_out, in_ready}, 2'b10);
        en = 1'b1;
        #1;
        chk(in_ready && tx_out, "R8 ready on re-enable", {in_ready, tx_out}, 2'b11);
        send(9'h0A7, 0, "after re-enable");

        // R9 no ticks freezes the line
        tick_hold = 1'b1;
        accept_word(9'h0FF);
        ok = 1'b1;
        repeat (60) begin step(); ok &= (!tx_out && !in_ready); end
        chk(ok, "R9 no tick holds start bit", {tx_out, in_ready}, 2'b00);
        tick_hold = 1'b0;
        begin
            int guard = 0;
            while (!in_ready && guard < 1000) begin step(); guard++; end
        end
        chk(in_ready && tx_out, "R9 resumes after ticks", {in_ready, tx_out}, 2'b11);

        // Random frames, random tick spacing
        for (int k = 0; k < 30; k++) begin
            cfg_len      = 2'($urandom_range(0, 3));
            cfg_parity   = 2'($urandom_range(0, 3));
            cfg_two_stop = 1'($urandom_range(0, 1));
            tick_per     = $urandom_range(1, 3);
            send(9'($urandom), 0, "random R2 R3");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired R1");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule